// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Walker

This block turns a stream of pixel bytes into addressed writes for a display RAM that holds 4-bit grayscale pixels, two per byte. The RAM is 64 byte-columns wide and 80 rows tall, 5120 bytes in all. Each byte presented with a write strobe goes out one cycle later with a write enable, the byte address of the current pointer position and the byte itself. The pointer then moves to the next position.

The pointer moves inside a rectangular window. A column window and a row window are each loaded with a start and an end value. A mode input picks the order of the walk. In horizontal mode the pointer moves along a row first and then steps down to the next row. In vertical mode it moves down a column first and then steps to the next column. Each accepted byte also gives a one-cycle dirty pulse, which a display refresh engine can use as a trigger. The RAM array itself and the command decoder that supplies the window bounds sit outside this block.

Top module: `fbw_addr_walker`

## Requirements
- R1: A write strobe with byte D at pointer (column c, row r) makes `ram_we` high in the next cycle, with `ram_addr` = c + 64·r, where c is in 0..63 and r is in 0..79.
- R2: With `vert_mode` = 0, each write moves the column up by one. When the column passes the column end, it returns to the column start and the row moves up by one. When the row passes the row end, it returns to the row start.
- R3: With `vert_mode` = 1, each write moves the row up by one. When the row passes the row end, it returns to the row start and the column moves up by one. When the column passes the column end, it returns to the column start.
- R4: A `col_load` pulse sets the current column and the column start to `col_lo` mod 64, and the column end to `col_hi` mod 64. The raw values cover the full 0..255 range.
- R5: A `row_load` pulse sets the current row and the row start to `row_lo` mod 80, and the row end to `row_hi` mod 80. The raw values cover the full 0..255 range, including values at or above 160 and 240.
- R6: After reset, `ram_we` and `dirty` are 0, the window spans columns 0..63 and rows 0..79, and the pointer is at (0,0).
- R7: `vert_mode` is read at each write, so changing it between writes changes the walk order from the next write on, starting from the current pointer.
- R8: An axis wraps only when its value plus one is greater than its end. If the end is below the start, that axis wraps on every step it takes and stays at its start, while the other axis takes a step on every write.
- R9: `ram_we` and `dirty` are high for exactly the one cycle after each accepted write strobe, and low in every other cycle.
- R10: `ram_wdata` in the `ram_we` cycle equals the byte that was presented with the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | Accept `wr_data` at the current pointer |
| wr_data | input | 8 | Pixel byte (two 4-bit pixels) |
| col_load | input | 1 | Load the column window from `col_lo`/`col_hi` |
| col_lo | input | 8 | Raw column start |
| col_hi | input | 8 | Raw column end |
| row_load | input | 1 | Load the row window from `row_lo`/`row_hi` |
| row_lo | input | 8 | Raw row start |
| row_hi | input | 8 | Raw row end |
| vert_mode | input | 1 | 1 = vertical-first walk, 0 = horizontal-first walk |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| dirty | output | 1 | One-cycle pulse per accepted write |

## Verification
The hardest case to reach is the double wrap, where the inner axis passes its end and at the same write the outer axis passes its end. It happens only once per full pass of the window. The bench reaches it by walking the full 64×80 window byte by byte in each mode, and by walking small and inverted windows several times over. The mod-80 reduction has three subtraction steps, and the steps above 160 and 240 are reached only with large raw bounds. The bench therefore sweeps every raw start value from 0 to 255 on both axes and checks the address of the first write after each load.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

   // True when v is a positive power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Number of compare-and-subtract steps needed to reduce an in_w-bit
   // value modulo m.
   function automatic int reduce_steps(input int in_w, input int m);
      return ((1 << in_w) - 1) / m;
   endfunction

endpackage

// File: rtl/fbw_mod_reduce.sv
module fbw_mod_reduce #(
   parameter int IN_W  = 8,
   parameter int MOD   = 80,
   localparam int OUT_W = $clog2(MOD)
) (
   input  logic [IN_W-1:0]  in_val,
   output logic [OUT_W-1:0] out_val
);
   import fbw_pkg::*;

   localparam int STEPS = reduce_steps(IN_W, MOD);

   initial begin
      if (MOD < 2 || MOD >= (1 << IN_W))
         $error("fbw_mod_reduce: MOD must be within 2..2**IN_W-1");
   end

   generate
      if (is_pow2(MOD)) begin : g_pow2
         // Power-of-two modulus: keep the low bits.
         logic [IN_W-1:0] rem;
         assign rem     = in_val % IN_W'(MOD);
         assign out_val = rem[OUT_W-1:0];
      end else begin : g_sub
         // Subtract the largest multiple of MOD that fits, one step per multiple.
         int v;
         always_comb begin
            v = int'(in_val);
            for (int k = STEPS; k >= 1; k--) begin
               if (v >= k * MOD) v = v - k * MOD;
            end
         end
         assign out_val = v[OUT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/fbw_axis.sv
module fbw_axis #(
   parameter int IN_W = 8,
   parameter int SIZE = 64,
   localparam int W   = $clog2(SIZE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [IN_W-1:0] lo_raw,
   input  logic [IN_W-1:0] hi_raw,
   input  logic            step,
   output logic [W-1:0]    cur,
   output logic [W-1:0]    first,
   output logic            carry
);

   logic [W-1:0] lo_mod;
   logic [W-1:0] hi_mod;
   logic [W-1:0] last;
   logic [W:0]   bumped;

   fbw_mod_reduce #(.IN_W(IN_W), .MOD(SIZE)) i_lo_red (.in_val(lo_raw), .out_val(lo_mod));
   fbw_mod_reduce #(.IN_W(IN_W), .MOD(SIZE)) i_hi_red (.in_val(hi_raw), .out_val(hi_mod));

   // Wrap when the value plus one goes beyond the end bound.
   assign bumped = {1'b0, cur} + (W + 1)'(1);
   assign carry  = bumped > {1'b0, last};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur   <= '0;
         first <= '0;
         last  <= W'(SIZE - 1);
      end else if (load) begin
         cur   <= lo_mod;
         first <= lo_mod;
         last  <= hi_mod;
      end else if (step) begin
         cur <= carry ? first : bumped[W-1:0];
      end
   end

endmodule

// File: rtl/fbw_addr_walker.sv
module fbw_addr_walker #(
   parameter int COLS   = 64,
   parameter int ROWS   = 80,
   parameter int DATA_W = 8,
   parameter int BND_W  = 8,
   localparam int COL_W  = $clog2(COLS),
   localparam int ROW_W  = $clog2(ROWS),
   localparam int ADDR_W = $clog2(COLS * ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              col_load,
   input  logic [BND_W-1:0]  col_lo,
   input  logic [BND_W-1:0]  col_hi,
   input  logic              row_load,
   input  logic [BND_W-1:0]  row_lo,
   input  logic [BND_W-1:0]  row_hi,
   input  logic              vert_mode,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              dirty
);
   import fbw_pkg::*;

   initial begin
      if (COLS < 2 || ROWS < 2)
         $error("fbw_addr_walker: window axes need at least two positions");
      if (COLS >= (1 << BND_W) || ROWS >= (1 << BND_W))
         $error("fbw_addr_walker: BND_W too narrow for the array");
   end

   logic [COL_W-1:0]  col_cur, col_first;
   logic [ROW_W-1:0]  row_cur, row_first;
   logic              col_carry, row_carry;
   logic              col_step, row_step;
   logic [ADDR_W-1:0] lin_addr;

   // The inner axis steps on every write, the outer one when the inner wraps.
   assign col_step = wr_strobe & (~vert_mode | row_carry);
   assign row_step = wr_strobe & ( vert_mode | col_carry);

   fbw_axis #(.IN_W(BND_W), .SIZE(COLS)) i_col (
      .clk(clk), .rst_n(rst_n), .load(col_load), .lo_raw(col_lo), .hi_raw(col_hi),
      .step(col_step), .cur(col_cur), .first(col_first), .carry(col_carry)
   );

   fbw_axis #(.IN_W(BND_W), .SIZE(ROWS)) i_row (
      .clk(clk), .rst_n(rst_n), .load(row_load), .lo_raw(row_lo), .hi_raw(row_hi),
      .step(row_step), .cur(row_cur), .first(row_first), .carry(row_carry)
   );

   generate
      if (is_pow2(COLS)) begin : g_concat_addr
         assign lin_addr = {row_cur, col_cur};
      end else begin : g_mul_addr
         assign lin_addr = ADDR_W'(row_cur) * ADDR_W'(COLS) + ADDR_W'(col_cur);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_we    <= 1'b0;
         dirty     <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else begin
         ram_we <= wr_strobe;
         dirty  <= wr_strobe;
         if (wr_strobe) begin
            ram_addr  <= lin_addr;
            ram_wdata <= wr_data;
         end
      end
   end

endmodule

// File: rtl/fbw_walker_chk.sv
module fbw_walker_chk #(
   parameter int COLS   = 64,
   parameter int ROWS   = 80,
   parameter int DATA_W = 8,
   parameter int COL_W  = 6,
   parameter int ROW_W  = 7,
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_strobe,
   input logic [DATA_W-1:0] wr_data,
   input logic              col_load,
   input logic              row_load,
   input logic              vert_mode,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic              dirty,
   input logic [COL_W-1:0]  col_cur,
   input logic [COL_W-1:0]  col_first,
   input logic [ROW_W-1:0]  row_cur,
   input logic [ROW_W-1:0]  row_first
);

   a_r1_addr_in_array: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (int'(ram_addr) < COLS * ROWS));

   a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(col_cur) < COLS) && (int'(row_cur) < ROWS));

   a_r9_pulse_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> (ram_we && dirty));

   a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe |=> (!ram_we && !dirty));

   a_r10_data_passes: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> (ram_wdata == $past(wr_data)));

   a_r2_row_moves_on_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !vert_mode && !col_load && !row_load)
      |=> ((row_cur == $past(row_cur)) || (col_cur == col_first)));

   a_r3_col_moves_on_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && vert_mode && !col_load && !row_load)
      |=> ((col_cur == $past(col_cur)) || (row_cur == row_first)));

endmodule

bind fbw_addr_walker fbw_walker_chk #(
   .COLS(COLS), .ROWS(ROWS), .DATA_W(DATA_W),
   .COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
   .col_load(col_load), .row_load(row_load), .vert_mode(vert_mode),
   .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .dirty(dirty),
   .col_cur(col_cur), .col_first(col_first), .row_cur(row_cur), .row_first(row_first)
);

// File: tb/test_fbw_addr_walker.sv
module test_fbw_addr_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_strobe = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        col_load = 1'b0;
   logic [7:0]  col_lo = '0, col_hi = '0;
   logic        row_load = 1'b0;
   logic [7:0]  row_lo = '0, row_hi = '0;
   logic        vert_mode = 1'b0;
   logic        ram_we;
   logic [12:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic        dirty;

   int checks = 0;
   int failures = 0;

   // Reference pointer and window.
   int m_col = 0, m_row = 0;
   int m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79;

   fbw_addr_walker i_fbw_addr_walker (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
      .col_load(col_load), .col_lo(col_lo), .col_hi(col_hi),
      .row_load(row_load), .row_lo(row_lo), .row_hi(row_hi),
      .vert_mode(vert_mode), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .dirty(dirty)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_step();
      if (!vert_mode) begin
         m_col++;
         if (m_col > m_ce) begin
            m_col = m_cs;
            m_row++;
            if (m_row > m_re) m_row = m_rs;
         end
      end else begin
         m_row++;
         if (m_row > m_re) begin
            m_row = m_rs;
            m_col++;
            if (m_col > m_ce) m_col = m_cs;
         end
      end
   endtask

   // Called at a negedge; returns at the negedge where the write is visible.
   task automatic do_write(input logic [7:0] d, input string tag);
      int exp_addr;
      exp_addr = m_col + m_row * 64;
      wr_strobe = 1'b1;
      wr_data   = d;
      @(negedge clk);
      wr_strobe = 1'b0;
      chk(ram_we === 1'b1 && dirty === 1'b1, "R9 we/dirty after write", int'({ram_we, dirty}), 3);
      chk(int'(ram_addr) == exp_addr, tag, int'(ram_addr), exp_addr);
      chk(ram_wdata === d, "R10 write data", int'(ram_wdata), int'(d));
      model_step();
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      chk(ram_we === 1'b0 && dirty === 1'b0, tag, int'({ram_we, dirty}), 0);
   endtask

   task automatic load_col(input int lo, input int hi);
      col_load = 1'b1;
      col_lo   = 8'(lo);
      col_hi   = 8'(hi);
      @(negedge clk);
      col_load = 1'b0;
      chk(ram_we === 1'b0 && dirty === 1'b0, "R9 no pulse on load", int'({ram_we, dirty}), 0);
      m_cs = lo % 64; m_col = m_cs; m_ce = hi % 64;
   endtask

   task automatic load_row(input int lo, input int hi);
      row_load = 1'b1;
      row_lo   = 8'(lo);
      row_hi   = 8'(hi);
      @(negedge clk);
      row_load = 1'b0;
      chk(ram_we === 1'b0 && dirty === 1'b0, "R9 no pulse on load", int'({ram_we, dirty}), 0);
      m_rs = lo % 80; m_row = m_rs; m_re = hi % 80;
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: outputs idle during and just after reset
      chk(ram_we === 1'b0 && dirty === 1'b0, "R6 reset outputs", int'({ram_we, dirty}), 0);
      rst_n = 1'b1;
      idle_check("R6 idle after reset");

      // R6: first write lands at (0,0)
      vert_mode = 1'b0;
      do_write(8'hA5, "R6 first address after reset");

      // R1 R2: full horizontal pass over the reset window, plus wrap
      for (int k = 1; k <= 5120; k++) do_write(8'(k ^ 8'h3C), "R1 R2 horizontal full window");

      // R3: full vertical pass, plus wrap
      vert_mode = 1'b1;
      for (int k = 0; k <= 5120; k++) do_write(8'(k * 7), "R3 vertical full window");
      idle_check("R9 idle gap");

      // R4: every raw column start value
      vert_mode = 1'b0;
      load_row(0, 79);
      for (int v = 0; v < 256; v++) begin
         load_col(v, 255 - v);
         do_write(8'(v), "R4 column load modulo 64");
         do_write(8'(~v), "R4 column load modulo 64 step");
      end

      // R5: every raw row start value, including >=160 and >=240
      vert_mode = 1'b1;
      load_col(0, 63);
      for (int v = 0; v < 256; v++) begin
         load_row(v, v ^ 8'hA5);
         do_write(8'(v), "R5 row load modulo 80");
         do_write(8'(v + 1), "R5 row load modulo 80 step");
      end

      // R2 R3: small window from large raw bounds (cols 5..9, rows 3..6)
      load_col(197, 73);
      load_row(83, 246);
      vert_mode = 1'b0;
      for (int k = 0; k < 45; k++) do_write(8'(k), "R2 small window horizontal");
      load_col(197, 73);
      load_row(83, 246);
      vert_mode = 1'b1;
      for (int k = 0; k < 45; k++) do_write(8'(k), "R3 small window vertical");

      // R7: mode switched between writes, mid-window
      for (int k = 0; k < 30; k++) begin
         vert_mode = k[2];
         do_write(8'(k + 100), "R7 mode change between writes");
      end

      // R8: inverted column window (10..4) with rows 2..5
      load_col(10, 4);
      load_row(2, 5);
      vert_mode = 1'b0;
      for (int k = 0; k < 12; k++) do_write(8'(k), "R8 inverted column window horizontal");
      vert_mode = 1'b1;
      for (int k = 0; k < 12; k++) do_write(8'(k), "R8 inverted column window vertical");

      // R8: inverted row window (70..20) with columns 60..62
      load_col(60, 62);
      load_row(70, 20);
      vert_mode = 1'b1;
      for (int k = 0; k < 10; k++) do_write(8'(k), "R8 inverted row window vertical");
      vert_mode = 1'b0;
      for (int k = 0; k < 10; k++) do_write(8'(k), "R8 inverted row window horizontal");
      idle_check("R9 idle at end");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule